// File: doc/BRIEF.md
# Event Interval Timer

This block measures how long passes between two events. One input pulse opens a measurement and a second input pulse closes it. While the measurement is open, a counter advances once per unit of the selected time base. The time base is one of three. The first is a fast tick at half the reference clock rate, which gives 100 ns steps from a 20 MHz reference. The second is a slow tick at one twentieth of the reference rate, which gives 1 µs steps. The third is one step for each qualified bus cycle flagged by an input strobe.

Both ticks are single-cycle enables made from the reference clock, so the design has one clock domain. The tick dividers restart when a measurement opens, which makes the result depend only on the number of reference cycles between the two events. The counter does not wrap: it stops at its all-ones value and raises an overflow flag. Once the measurement is closed the count holds still. A host then reads it one byte at a time through a byte-select address. A synchronous clear input returns the block to its idle, zeroed state.

Top module: `interval_timer`

## Requirements
- R1: After reset the count is zero, `running` is 0 and `overflow` is 0.
- R2: When `start_evt` is high while idle, `running` rises on the next clock edge and the count and `overflow` are zeroed. A `start_evt` while running has no effect on the count or the tick phase.
- R3: When `stop_evt` is high while running, `running` falls on that edge and no increment happens on that edge. A `stop_evt` while idle is ignored. If `start_evt` and `stop_evt` are high together while idle, the start is taken.
- R4: With `src_sel` = 0 (fast tick, one step per FAST_DIV clocks, default 2), a measurement whose stop edge comes L edges after its start edge ends with count floor((L-1)/FAST_DIV).
- R5: With `src_sel` = 1 (slow tick, one step per SLOW_DIV clocks, default 20), the final count is floor((L-1)/SLOW_DIV).
- R6: With `src_sel` = 2 (bus cycles), the final count equals the number of clock edges strictly between the start edge and the stop edge at which `bus_cycle` is high.
- R7: With `src_sel` = 3, nothing is counted and the final count is zero.
- R8: The count saturates at 2^CNT_W-1. `overflow` is set only when an increment is requested while the count is already at that value.
- R9: `rd_data` reflects `rd_addr` without a clock. Address 0 gives count bits 7:0, address 1 gives bits 15:8, and address 2 gives bits 23:16, with bits above CNT_W reading 0. Address 3 gives `{6'b0, running, overflow}`.
- R10: While idle and with no start or clear, the count does not change.
- R11: When `clr` is high on an edge, the count, `overflow` and `running` become 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (20 MHz in the intended use) |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of count, overflow and running state |
| start_evt | input | 1 | Pulse that opens a measurement |
| stop_evt | input | 1 | Pulse that closes a measurement |
| bus_cycle | input | 1 | Strobe marking one qualified bus cycle |
| src_sel | input | 2 | Time base: 0 fast tick, 1 slow tick, 2 bus cycles, 3 none |
| rd_addr | input | 2 | Readback byte select |
| rd_data | output | 8 | Selected readback byte |
| running | output | 1 | Measurement open |
| overflow | output | 1 | Count saturated with an increment refused |

## Verification
The open and close pulses take effect on the edge that samples them. Counts, `running` and `overflow` are therefore visible one edge after the stimulus, and the readback byte follows the address within the same cycle. The bench drives every input on the falling edge and reads results half a cycle later, so each value it compares is the one registered on the preceding rising edge. For each time base it sweeps the interval length from one edge up to several tick periods and computes the expected count from the interval length, or from the strobes it drove. Near saturation it uses a 12-bit counter, so the all-ones boundary and the first refused increment are both reached within a few thousand cycles.

// File: rtl/it_pkg.sv
// Shared types for the event interval timer.
// Assumes a 2-bit source select and readback address fixed by the top ports.
package it_pkg;

    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_BUS  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        RD_BYTE0  = 2'd0,
        RD_BYTE1  = 2'd1,
        RD_BYTE2  = 2'd2,
        RD_STATUS = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/it_tick_gen.sv
// Tick generator: one-cycle enable every DIV clocks while run is high.
// Assumes DIV >= 2. The phase is cleared by restart, so the first tick
// comes DIV edges after the restart edge.
module it_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] phase_q;

    // Phase counter: wraps at DIV-1, cleared on restart, held while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    // Tick fires on the last phase of each period.
    always_comb tick = run && (phase_q == LAST);

endmodule

// File: rtl/it_src_mux.sv
// Time-base selector: picks the increment request from the two ticks,
// the bus-cycle strobe, or nothing. Purely combinational.
module it_src_mux (
    input  logic [1:0] ticks,
    input  logic       bus_cycle,
    input  logic [1:0] sel,
    output logic       inc_req
);
    import it_pkg::*;

    // Select the increment source by encoding.
    always_comb begin
        unique case (src_e'(sel))
            SRC_FAST: inc_req = ticks[0];
            SRC_SLOW: inc_req = ticks[1];
            SRC_BUS:  inc_req = bus_cycle;
            default:  inc_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/it_counter.sv
// Start/stop control and saturating interval counter.
// Assumes single-cycle event pulses; clr has priority over all events.
// A stop edge does not count; a start while running is ignored.
module it_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             inc_req,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             overflow
);
    localparam logic [CNT_W-1:0] MAX = '1;

    // Measurement state machine with saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count    <= '0;
            running  <= 1'b0;
            overflow <= 1'b0;
        end else if (!running) begin
            if (start_evt) begin
                running  <= 1'b1;
                count    <= '0;
                overflow <= 1'b0;
            end
        end else if (stop_evt) begin
            running <= 1'b0;
        end else if (inc_req) begin
            if (count == MAX) begin
                overflow <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/it_readback.sv
// Byte readback: maps the count into byte lanes and a status byte.
// Assumes CNT_W <= 3*BYTE_W; unused upper bits read as zero.
module it_readback #(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8
) (
    input  logic [CNT_W-1:0]  count,
    input  logic              running,
    input  logic              overflow,
    input  logic [1:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    import it_pkg::*;

    localparam int PAD_W = 3 * BYTE_W;

    logic [PAD_W-1:0] padded;

    // Zero-extend the count to three full byte lanes.
    always_comb padded = PAD_W'(count);

    // Return the addressed lane or the status byte.
    always_comb begin
        unique case (rd_sel_e'(rd_addr))
            RD_BYTE0: rd_data = padded[0*BYTE_W +: BYTE_W];
            RD_BYTE1: rd_data = padded[1*BYTE_W +: BYTE_W];
            RD_BYTE2: rd_data = padded[2*BYTE_W +: BYTE_W];
            default:  rd_data = {{(BYTE_W-2){1'b0}}, running, overflow};
        endcase
    end

endmodule

// File: rtl/interval_timer.sv
// Event interval timer top: tick generators, source selector,
// start/stop counter and byte readback. Single clock domain; ticks are
// clock enables. Assumes CNT_W <= 24 and both dividers >= 2.
module interval_timer #(
    parameter int CNT_W    = 24,
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 20,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bus_cycle,
    input  logic [1:0]        src_sel,
    input  logic [1:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              running,
    output logic              overflow
);
    localparam int N_TICK = 2;

    logic [CNT_W-1:0]  count_q;
    logic [N_TICK-1:0] ticks;
    logic              inc_req;
    logic              restart;

    // Dividers restart on an accepted start or a clear.
    always_comb restart = clr || (start_evt && !running);

    genvar g;
    generate
        for (g = 0; g < N_TICK; g++) begin : g_tick
            it_tick_gen #(
                .DIV ((g == 0) ? FAST_DIV : SLOW_DIV)
            ) u_tick (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (restart),
                .run     (running),
                .tick    (ticks[g])
            );
        end
    endgenerate

    it_src_mux u_mux (
        .ticks     (ticks),
        .bus_cycle (bus_cycle),
        .sel       (src_sel),
        .inc_req   (inc_req)
    );

    it_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .inc_req   (inc_req),
        .count     (count_q),
        .running   (running),
        .overflow  (overflow)
    );

    it_readback #(
        .CNT_W  (CNT_W),
        .BYTE_W (BYTE_W)
    ) u_rd (
        .count    (count_q),
        .running  (running),
        .overflow (overflow),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/it_checker.sv
// Property checker for interval_timer, attached by bind.
// Observes the ports and the internal count; drives nothing.
module it_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             start_evt,
    input logic             stop_evt,
    input logic             running,
    input logic             overflow,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAX = '1;

    // R2: an accepted start opens the measurement with a zero count.
    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start_evt && !clr) |=> (running && count == '0 && !overflow));

    // R3: a stop while running closes the measurement.
    p_stop_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop_evt && !clr) |=> !running);

    // R3: the stop edge adds nothing to the count.
    p_stop_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop_evt && !clr) |=> $stable(count));

    // R8: while running the count moves by at most one per edge.
    p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !clr) |=> (count == $past(count) || count == $past(count) + 1'b1));

    // R8: overflow rises only at the saturated value.
    p_ovf_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (count == MAX));

    // R10: an idle timer holds its count and stays idle.
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_evt && !clr) |=> ($stable(count) && !running));

    // R11: clear zeroes everything.
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !running && !overflow));

endmodule

bind interval_timer it_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .running   (running),
    .overflow  (overflow),
    .count     (count_q)
);

// File: tb/interval_timer_bench.sv
// Bench for interval_timer with a 12-bit counter: sweeps interval lengths
// on every time base and walks the saturation boundary.
module interval_timer_bench;
    localparam int CW  = 12;
    localparam int MAXV = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       bus_cycle = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       running;
    logic       overflow;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    interval_timer #(.CNT_W(CW)) u_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .bus_cycle (bus_cycle),
        .src_sel   (src_sel),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .running   (running),
        .overflow  (overflow)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic read_byte(input int a, output int v);
        rd_addr = 2'(a);
        #2;
        v = int'(rd_data);
    endtask

    task automatic read_count(output int v);
        int lo, hi;
        read_byte(0, lo);
        read_byte(1, hi);
        v = lo + (hi << 8);
    endtask

    // One measurement of len edges from start to stop; returns strobes driven.
    task automatic run_iv(input int src, input int len, input bit all_bus, output int bus_n);
        bus_n = 0;
        @(negedge clk);
        src_sel = 2'(src);
        start_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
        for (int j = 1; j < len; j++) begin
            bus_cycle = all_bus || (j % 3 != 0);
            if (bus_cycle) bus_n++;
            @(negedge clk);
        end
        bus_cycle = 1'b0;
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, bn, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_count(v);
        check("R1 count after reset", v, 0);
        check("R1 running after reset", int'(running), 0);
        check("R1 overflow after reset", int'(overflow), 0);

        // R4 R5 R6 R7: sweep interval lengths on every source
        for (int src = 0; src < 4; src++) begin
            for (int len = 1; len <= 45; len++) begin
                run_iv(src, len, 1'b0, bn);
                read_count(v);
                case (src)
                    0: exp = (len - 1) / 2;
                    1: exp = (len - 1) / 20;
                    2: exp = bn;
                    default: exp = 0;
                endcase
                case (src)
                    0: check("R4 fast tick count", v, exp);
                    1: check("R5 slow tick count", v, exp);
                    2: check("R6 bus cycle count", v, exp);
                    default: check("R7 no source count", v, exp);
                endcase
                check("R3 running low after stop", int'(running), 0);
            end
        end

        // R10 R3: stop while idle, with bus strobes, changes nothing
        run_iv(2, 10, 1'b1, bn);
        bus_cycle = 1'b1;
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        repeat (5) @(negedge clk);
        bus_cycle = 1'b0;
        read_count(v);
        check("R10 count frozen while idle", v, 9);
        check("R3 idle stop ignored", int'(running), 0);

        // R2: second start while running is ignored (restart would give 7)
        @(negedge clk);
        src_sel = 2'd0;
        start_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
        check("R2 running after start", int'(running), 1);
        for (int j = 1; j < 20; j++) begin
            start_evt = (j == 5);
            @(negedge clk);
        end
        start_evt = 1'b0;
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        read_count(v);
        check("R2 start while running ignored", v, 9);

        // R3: start and stop together while idle -> start wins
        start_evt = 1'b1;
        stop_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
        stop_evt = 1'b0;
        check("R3 simultaneous start taken", int'(running), 1);
        read_count(v);
        check("R2 count zeroed on start", v, 0);
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;

        // R8: exactly full, no overflow
        run_iv(2, MAXV + 1, 1'b1, bn);
        read_count(v);
        check("R8 count at max", v, MAXV);
        check("R8 no overflow at max", int'(overflow), 0);

        // R8: one increment past full sets overflow, count holds
        run_iv(2, MAXV + 2, 1'b1, bn);
        read_count(v);
        check("R8 saturated count", v, MAXV);
        check("R8 overflow set", int'(overflow), 1);
        read_byte(3, v);
        check("R9 status byte overflow", v, 1);

        // R2: new start clears overflow
        start_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
        check("R2 overflow cleared by start", int'(overflow), 0);
        read_byte(3, v);
        check("R9 status byte running", v, 2);
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;

        // R9: byte lanes of 0xABC
        run_iv(2, 16'hABC + 1, 1'b1, bn);
        read_byte(0, v);
        check("R9 byte 0", v, 'hBC);
        read_byte(1, v);
        check("R9 byte 1", v, 'h0A);
        read_byte(2, v);
        check("R9 byte 2 above width", v, 0);

        // R11: clear during a run
        src_sel = 2'd2;
        bus_cycle = 1'b1;
        start_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
        repeat (10) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        bus_cycle = 1'b0;
        read_count(v);
        check("R11 count cleared", v, 0);
        check("R11 running cleared", int'(running), 0);
        check("R11 overflow cleared", int'(overflow), 0);

        // R4: normal operation after clear
        run_iv(0, 11, 1'b0, bn);
        read_count(v);
        check("R4 fast count after clear", v, 5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule